// File: doc/BRIEF.md
# Vendor Control Request Dispatcher

This block sits behind a USB device controller and serves vendor-specific control requests on endpoint zero. The controller presents each setup packet as one parallel word with a one-cycle valid strobe: the request type byte, the request code, and the low byte of the value field. The block checks that the request is a vendor request aimed at the device, with the right transfer direction for its code. It then runs the command and answers one cycle later with either a response (up to six bytes plus a byte count) or a one-cycle stall.

The commands act on the block's own state: an 8-bit up/down debug counter, an LNB supply control register with a +1 V boost code, and the data and output-enable registers of GPIO port B. A read command samples one sense input. The block does not serialise switch commands itself. It passes a 7-bit word and a start pulse to an external serializer.

Top module: `vreq_dispatch`

## Requirements
- R1: A request is accepted only when request type bits 6:5 are 2'b10 (vendor) and bits 4:0 are zero (device recipient). Type bit 7 must also match the code's direction: 1 for 0x91, 0x92 and 0x98, and 0 for 0x8F, 0x94, 0x96 and 0x97.
- R2: A request that is rejected by R1, whose code is outside 0x80..0x9D, or whose code is in that range but is not one of the seven listed codes raises resp_stall_o for one cycle. It leaves resp_valid_o low and changes no register, counter or output.
- R3: resp_valid_o or resp_stall_o rises exactly one cycle after setup_valid_i and stays high for a single cycle.
- R4: Code 0x91 increments the 8-bit counter (wrapping) if the value byte is nonzero, and decrements it (wrapping) if the value byte is zero. It returns the updated counter in byte 0 with count 1.
- R5: Code 0x92 returns count 6. The bytes, from byte 0 (resp_data_o[7:0]) upward, are build 0x02, minor 0x05, major 0x01, day 0x1C, month 0x02 and year-2000 0x19.
- R6: Code 0x94 sets lnb_ctrl_o to 0x6A for a nonzero value byte and to 0x62 for a zero value byte, with count 0 and data bytes zero.
- R7: Code 0x96 with a nonzero value byte sets pb_data_o to (pb_data_o AND 0xF7) OR 0x06 and pb_oe_o to 0xFE. With a zero value byte it sets pb_oe_o to 0xF0 and keeps pb_data_o. The count is 0.
- R8: Code 0x97 sets pb_data_o to (pb_data_o AND 0xF1) OR (value byte AND 0x0E), with count 0.
- R9: Code 0x98 returns pb_sense_i, as sampled in the setup cycle, as byte 0 (0x00 or 0x01) with count 1.
- R10: Code 0x8F pulses sw_start_o in the same cycle as resp_valid_o, with sw_word_o equal to the low 7 bits of the value byte, and answers with count 0.
- R11: After reset the counter is 0x00, lnb_ctrl_o is 0x62, pb_oe_o is 0xF0, pb_data_o is 0x00, and all strobes, the count and the data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | Setup packet present this cycle |
| req_type_i | input | 8 | Request type byte |
| req_code_i | input | 8 | Request code |
| wvalue_lo_i | input | 8 | Low byte of the value field |
| pb_sense_i | input | 1 | Port B sense input read by 0x98 |
| resp_valid_o | output | 1 | Response ready, one cycle |
| resp_stall_o | output | 1 | Request refused, one cycle |
| resp_count_o | output | 3 | Response byte count |
| resp_data_o | output | 48 | Response bytes, byte 0 in bits 7:0 |
| sw_start_o | output | 1 | Start pulse to the switch serializer |
| sw_word_o | output | 7 | Switch command word |
| lnb_ctrl_o | output | 8 | LNB supply control register |
| pb_data_o | output | 8 | Port B data register |
| pb_oe_o | output | 8 | Port B output-enable register |

## Verification
The assertions watch several properties on every cycle. Responses and stalls follow a setup strobe by one cycle and never coincide. A stall leaves the LNB and port B registers untouched. The counter and LNB register hold when not commanded. Port B bits outside 3..1 survive a pin write, and the output enable only takes its two legal patterns. Only the bench's scenarios can show the actual values: the counter's wrap in both directions, the version byte order, each register code and masked update, the direction and recipient filtering, and the switch word.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned RESP_BYTES = 6;
  localparam int unsigned RESP_W     = DATA_W * RESP_BYTES;
  localparam int unsigned CNT_W      = $clog2(RESP_BYTES + 1);

  localparam logic [7:0] DISPATCH_BASE = 8'h80;
  localparam logic [7:0] DISPATCH_SPAN = 8'h1E;

  localparam logic [7:0] OP_SWITCH  = 8'h8F;
  localparam logic [7:0] OP_COUNT   = 8'h91;
  localparam logic [7:0] OP_VERSION = 8'h92;
  localparam logic [7:0] OP_BOOST   = 8'h94;
  localparam logic [7:0] OP_PB_MODE = 8'h96;
  localparam logic [7:0] OP_PB_WR   = 8'h97;
  localparam logic [7:0] OP_PB_RD   = 8'h98;

  localparam logic [7:0] LNB_BOOST_ON  = 8'h6A;
  localparam logic [7:0] LNB_BOOST_OFF = 8'h62;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_SWITCH, CMD_COUNT, CMD_VERSION,
    CMD_BOOST, CMD_PB_MODE, CMD_PB_WR, CMD_PB_RD
  } cmd_e;
endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
  import vreq_pkg::*;
(
  input  logic [7:0] req_type_i,
  input  logic [7:0] req_code_i,
  output cmd_e       cmd_o,
  output logic       stall_o
);
  logic [7:0] idx;
  logic       in_range, type_ok, dir_in, ok;
  cmd_e       cmd_raw;

  assign idx      = req_code_i - DISPATCH_BASE;
  assign in_range = req_code_i[7] && (idx < DISPATCH_SPAN);
  // vendor class, device recipient; direction bit checked per code
  assign type_ok  = (req_type_i[6:0] == 7'h40);

  always_comb begin
    cmd_raw = CMD_NONE;
    dir_in  = 1'b0;
    unique case (req_code_i)
      OP_SWITCH:  cmd_raw = CMD_SWITCH;
      OP_COUNT:   begin cmd_raw = CMD_COUNT;   dir_in = 1'b1; end
      OP_VERSION: begin cmd_raw = CMD_VERSION; dir_in = 1'b1; end
      OP_BOOST:   cmd_raw = CMD_BOOST;
      OP_PB_MODE: cmd_raw = CMD_PB_MODE;
      OP_PB_WR:   cmd_raw = CMD_PB_WR;
      OP_PB_RD:   begin cmd_raw = CMD_PB_RD;   dir_in = 1'b1; end
      default:    cmd_raw = CMD_NONE;
    endcase
  end

  assign ok      = in_range && type_ok && (cmd_raw != CMD_NONE) && (req_type_i[7] == dir_in);
  assign cmd_o   = ok ? cmd_raw : CMD_NONE;
  assign stall_o = !ok;
endmodule

// File: rtl/vreq_ctrl_regs.sv
module vreq_ctrl_regs
  import vreq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              cnt_up_i,
  input  logic              lnb_en_i,
  input  logic              lnb_boost_i,
  output logic [DATA_W-1:0] cnt_q_o,
  output logic [DATA_W-1:0] cnt_next_o,
  output logic [DATA_W-1:0] lnb_o
);
  logic [DATA_W-1:0] cnt_q, lnb_q;

  assign cnt_next_o = cnt_up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lnb_q <= LNB_BOOST_OFF;
    end else begin
      if (cnt_en_i) cnt_q <= cnt_next_o;
      if (lnb_en_i) lnb_q <= lnb_boost_i ? LNB_BOOST_ON : LNB_BOOST_OFF;
    end
  end

  assign cnt_q_o = cnt_q;
  assign lnb_o   = lnb_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_q)); // R4
  AST_LNB_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnb_q == LNB_BOOST_ON) || (lnb_q == LNB_BOOST_OFF)); // R6
  AST_LNB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lnb_en_i |=> $stable(lnb_q)); // R6
endmodule

// File: rtl/vreq_portb.sv
module vreq_portb
  import vreq_pkg::*;
#(
  parameter logic [DATA_W-1:0] PIN_MASK   = 8'h0E,
  parameter logic [DATA_W-1:0] MODE_CLR   = 8'h08,
  parameter logic [DATA_W-1:0] MODE_SET   = 8'h06,
  parameter logic [DATA_W-1:0] OE_ACTIVE  = 8'hFE,
  parameter logic [DATA_W-1:0] OE_DEFAULT = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              mode_flag_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_val_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] oe_o
);
  logic [DATA_W-1:0] data_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= OE_DEFAULT;
    end else if (mode_en_i) begin
      oe_q <= mode_flag_i ? OE_ACTIVE : OE_DEFAULT;
      if (mode_flag_i) data_q <= (data_q & ~MODE_CLR) | MODE_SET;
    end else if (wr_en_i) begin
      data_q <= (data_q & ~PIN_MASK) | (wr_val_i & PIN_MASK);
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;

  AST_PB_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_en_i) |=> ((data_q & ~PIN_MASK) == ($past(data_q) & ~PIN_MASK))); // R8
  AST_PB_OE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q == OE_ACTIVE) || (oe_q == OE_DEFAULT)); // R7
  AST_PB_MODE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && !mode_flag_i) |=> $stable(data_q)); // R7
endmodule

// File: rtl/vreq_dispatch.sv
module vreq_dispatch
  import vreq_pkg::*;
#(
  parameter logic [7:0] VER_BUILD = 8'h02,
  parameter logic [7:0] VER_MINOR = 8'h05,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_DAY   = 8'h1C,
  parameter logic [7:0] VER_MONTH = 8'h02,
  parameter logic [7:0] VER_YEAR  = 8'h19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_valid_i,
  input  logic [7:0]        req_type_i,
  input  logic [7:0]        req_code_i,
  input  logic [7:0]        wvalue_lo_i,
  input  logic              pb_sense_i,
  output logic              resp_valid_o,
  output logic              resp_stall_o,
  output logic [CNT_W-1:0]  resp_count_o,
  output logic [RESP_W-1:0] resp_data_o,
  output logic              sw_start_o,
  output logic [6:0]        sw_word_o,
  output logic [7:0]        lnb_ctrl_o,
  output logic [7:0]        pb_data_o,
  output logic [7:0]        pb_oe_o
);
  cmd_e              cmd;
  logic              stall, flag, fire;
  logic [DATA_W-1:0] cnt_q, cnt_next;
  logic [CNT_W-1:0]  count_d;
  logic [RESP_W-1:0] data_d;

  assign flag = |wvalue_lo_i;
  assign fire = setup_valid_i && !stall;

  vreq_decode i_decode (
    .req_type_i (req_type_i),
    .req_code_i (req_code_i),
    .cmd_o      (cmd),
    .stall_o    (stall)
  );

  vreq_ctrl_regs i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_en_i    (fire && cmd == CMD_COUNT),
    .cnt_up_i    (flag),
    .lnb_en_i    (fire && cmd == CMD_BOOST),
    .lnb_boost_i (flag),
    .cnt_q_o     (cnt_q),
    .cnt_next_o  (cnt_next),
    .lnb_o       (lnb_ctrl_o)
  );

  vreq_portb i_portb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_en_i   (fire && cmd == CMD_PB_MODE),
    .mode_flag_i (flag),
    .wr_en_i     (fire && cmd == CMD_PB_WR),
    .wr_val_i    (wvalue_lo_i),
    .data_o      (pb_data_o),
    .oe_o        (pb_oe_o)
  );

  always_comb begin
    count_d = '0;
    data_d  = '0;
    unique case (cmd)
      CMD_COUNT: begin
        count_d = CNT_W'(1);
        data_d  = RESP_W'(cnt_next);
      end
      CMD_VERSION: begin
        count_d = CNT_W'(RESP_BYTES);
        data_d  = {VER_YEAR, VER_MONTH, VER_DAY, VER_MAJOR, VER_MINOR, VER_BUILD};
      end
      CMD_PB_RD: begin
        count_d = CNT_W'(1);
        data_d  = RESP_W'(pb_sense_i);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_stall_o <= 1'b0;
      resp_count_o <= '0;
      resp_data_o  <= '0;
      sw_start_o   <= 1'b0;
      sw_word_o    <= '0;
    end else begin
      resp_valid_o <= fire;
      resp_stall_o <= setup_valid_i && stall;
      sw_start_o   <= fire && cmd == CMD_SWITCH;
      if (fire) begin
        resp_count_o <= count_d;
        resp_data_o  <= data_d;
        if (cmd == CMD_SWITCH) sw_word_o <= wvalue_lo_i[6:0];
      end
    end
  end

  AST_RESP_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o || resp_stall_o) |-> $past(setup_valid_i)); // R3
  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resp_valid_o && resp_stall_o)); // R2
  AST_STALL_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_stall_o |-> ($stable(lnb_ctrl_o) && $stable(pb_data_o) && $stable(pb_oe_o) && $stable(cnt_q))); // R2
  AST_COUNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_count_o <= CNT_W'(RESP_BYTES))); // R5
  AST_SW_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_start_o |-> (resp_valid_o && resp_count_o == '0)); // R10
endmodule

// File: tb/test_vreq_dispatch.sv
module test_vreq_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_valid = 1'b0;
  logic [7:0]  req_type = '0, req_code = '0, wvalue = '0;
  logic        sense = 1'b0;
  logic        resp_valid, resp_stall, sw_start;
  logic [2:0]  resp_count;
  logic [47:0] resp_data;
  logic [6:0]  sw_word;
  logic [7:0]  lnb, pbd, pboe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] m_cnt = 8'h00, m_lnb = 8'h62, m_pbd = 8'h00, m_pboe = 8'hF0;
  logic [6:0] m_sw = '0;

  always #4 clk = ~clk;

  vreq_dispatch i_vreq_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .setup_valid_i(setup_valid),
    .req_type_i(req_type), .req_code_i(req_code), .wvalue_lo_i(wvalue),
    .pb_sense_i(sense), .resp_valid_o(resp_valid), .resp_stall_o(resp_stall),
    .resp_count_o(resp_count), .resp_data_o(resp_data), .sw_start_o(sw_start),
    .sw_word_o(sw_word), .lnb_ctrl_o(lnb), .pb_data_o(pbd), .pb_oe_o(pboe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic is_in(input logic [7:0] c);
    return (c == 8'h91) || (c == 8'h92) || (c == 8'h98);
  endfunction

  function automatic logic is_impl(input logic [7:0] c);
    return (c == 8'h8F) || (c == 8'h91) || (c == 8'h92) || (c == 8'h94) ||
           (c == 8'h96) || (c == 8'h97) || (c == 8'h98);
  endfunction

  task automatic do_req(input logic [7:0] t, input logic [7:0] c,
                        input logic [7:0] v, input logic s);
    logic ok;
    logic [2:0]  e_cnt;
    logic [47:0] e_data;
    ok = is_impl(c) && (t[6:0] == 7'h40) && (t[7] == is_in(c));
    e_cnt = '0;
    e_data = '0;
    if (ok) begin
      case (c)
        8'h8F: m_sw = v[6:0];
        8'h91: begin
          m_cnt = (v != 0) ? m_cnt + 8'd1 : m_cnt - 8'd1;
          e_cnt = 3'd1; e_data = {40'd0, m_cnt};
        end
        8'h92: begin e_cnt = 3'd6; e_data = 48'h19_02_1C_01_05_02; end
        8'h94: m_lnb = (v != 0) ? 8'h6A : 8'h62;
        8'h96: begin
          if (v != 0) begin m_pbd = (m_pbd & 8'hF7) | 8'h06; m_pboe = 8'hFE; end
          else m_pboe = 8'hF0;
        end
        8'h97: m_pbd = (m_pbd & 8'hF1) | (v & 8'h0E);
        8'h98: begin e_cnt = 3'd1; e_data = {47'd0, s}; end
        default: ;
      endcase
    end
    @(negedge clk);
    setup_valid = 1'b1; req_type = t; req_code = c; wvalue = v; sense = s;
    @(negedge clk);
    setup_valid = 1'b0; sense = ~s;
    chk("R3 R1 valid", 64'(resp_valid), 64'(ok));
    chk("R2 stall", 64'(resp_stall), 64'(!ok));
    if (ok) begin
      chk("R4 R5 R9 count", 64'(resp_count), 64'(e_cnt));
      chk("R4 R5 R9 data", 64'(resp_data), 64'(e_data));
    end
    chk("R10 sw_start", 64'(sw_start), 64'(ok && c == 8'h8F));
    if (ok && c == 8'h8F) chk("R10 sw_word", 64'(sw_word), 64'(m_sw));
    chk("R6 lnb", 64'(lnb), 64'(m_lnb));
    chk("R7 R8 pb data", 64'(pbd), 64'(m_pbd));
    chk("R7 pb oe", 64'(pboe), 64'(m_pboe));
    @(negedge clk);
    chk("R3 single cycle", 64'({resp_valid, resp_stall, sw_start}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] codes [13];
    void'($urandom(32'd4711));
    codes = '{8'h8F, 8'h91, 8'h92, 8'h94, 8'h96, 8'h97, 8'h98,
              8'h90, 8'h93, 8'h9D, 8'h9E, 8'h7F, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 strobes", 64'({resp_valid, resp_stall, sw_start}), 64'd0);
    chk("R11 count/data", 64'({resp_count, resp_data}), 64'd0);
    chk("R11 lnb", 64'(lnb), 64'h62);
    chk("R11 pb oe", 64'(pboe), 64'hF0);
    chk("R11 pb data", 64'(pbd), 64'h00);
    // R4 wrap down from reset, then up across 0xFF
    do_req(8'hC0, 8'h91, 8'h00, 1'b0);
    do_req(8'hC0, 8'h91, 8'h80, 1'b0);
    do_req(8'hC0, 8'h91, 8'h01, 1'b0);
    // R5 version
    do_req(8'hC0, 8'h92, 8'h00, 1'b0);
    // R6 both codes
    do_req(8'h40, 8'h94, 8'h10, 1'b0);
    do_req(8'h40, 8'h94, 8'h00, 1'b0);
    // R8 then R7 both modes
    do_req(8'h40, 8'h97, 8'hFF, 1'b0);
    do_req(8'h40, 8'h96, 8'h01, 1'b0);
    do_req(8'h40, 8'h97, 8'hF0, 1'b0);
    do_req(8'h40, 8'h96, 8'h00, 1'b0);
    // R9 both levels
    do_req(8'hC0, 8'h98, 8'h00, 1'b1);
    do_req(8'hC0, 8'h98, 8'h00, 1'b0);
    // R10 bit 7 of value dropped
    do_req(8'h40, 8'h8F, 8'hD5, 1'b0);
    // R1 wrong direction / recipient / class, R2 unimplemented and out of range
    do_req(8'h40, 8'h91, 8'h01, 1'b0);
    do_req(8'hC0, 8'h94, 8'h01, 1'b0);
    do_req(8'h41, 8'h97, 8'h0E, 1'b0);
    do_req(8'h00, 8'h96, 8'h01, 1'b0);
    do_req(8'h40, 8'h9D, 8'h01, 1'b0);
    do_req(8'h40, 8'h9E, 8'h01, 1'b0);
    do_req(8'h40, 8'h7F, 8'h01, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c, t, v;
      c = codes[$urandom_range(0, 12)];
      if ($urandom_range(0, 3) == 0) c = 8'($urandom);
      case ($urandom_range(0, 5))
        0: t = 8'($urandom);
        1: t = is_in(c) ? 8'h40 : 8'hC0;
        default: t = is_in(c) ? 8'hC0 : 8'h40;
      endcase
      v = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      do_req(t, c, v, 1'($urandom));
    end
    finish_run();
  end
endmodule